// File: doc/BRIEF.md
# Dual-Arrival Receive Buffer with Early Stall Request

This block is the input queue that sits between a processing element and the two segmented message buses of a data-parallel array, one carrying traffic leftward and one rightward. A message that reaches its destination has to be taken in the cycle it appears; the bus cannot hold it there. Either bus can deliver in any cycle, and both can deliver in the same cycle. The queue therefore stores up to two messages per clock edge. The processing element removes the oldest message, one per receive instruction.

The bus network stops only after a fixed halt latency. For that reason the queue asks for a stall early, before it is full. It keeps slack entries equal to the halt latency times the peak arrival rate of two, so a late stall never costs a message. The request drops again once occupancy falls back below the threshold. A head-valid output shows that at least one message is waiting, for the array-wide completion detector. A sticky error flag records any arrival that found no room, and such an arrival is dropped.

Top module: `rx_stall_fifo`

## Requirements
- R1: When both buses deliver in the same cycle, both messages are stored on that edge, and the left-bus message is placed ahead of the right-bus message.
- R2: Messages leave in arrival order. `head_msg` shows the oldest stored message, and an accepted `rd_en` removes it at the next edge.
- R3: `stall_req` is high whenever occupancy is at or above the threshold WORK-2+1 (3 by default). This is the occupancy at which one more cycle of double arrivals could pass the working capacity WORK.
- R4: `stall_req` returns low as soon as occupancy is below the threshold again.
- R5: Total capacity is WORK + 2*HALT_LAT entries (6 by default). Filling it exactly, including during a stall raised one cycle earlier, sets no error.
- R6: A removal and up to two arrivals may fall in the same cycle. Occupancy changes by the net amount, and this works even when the buffer is full.
- R7: `rd_en` while the buffer is empty is ignored: occupancy stays zero and a later arrival becomes the head.
- R8: `head_vld` is 1 exactly when at least one message is stored.
- R9: An arrival that finds no room after this cycle's removal is dropped, with the left message taking room first. `ovf_err` is set and stays 1 until reset, and the stored messages are unchanged.
- R10: After reset the buffer is empty, and `stall_req`, `head_vld` and `ovf_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lft_vld | input | 1 | Left-moving bus delivers a message this cycle |
| lft_msg | input | DATA_W | Message from the left-moving bus |
| rgt_vld | input | 1 | Right-moving bus delivers a message this cycle |
| rgt_msg | input | DATA_W | Message from the right-moving bus |
| rd_en | input | 1 | Receive instruction: remove the head message |
| head_vld | output | 1 | At least one message stored |
| head_msg | output | DATA_W | Oldest stored message |
| stall_req | output | 1 | Occupancy at or above the stall threshold |
| ovf_err | output | 1 | Sticky: an arrival was dropped for lack of room |

## Verification
Two functions can fall in the same cycle here: a removal by the receive instruction and one or two bus arrivals. The stimulus table provokes this at mid occupancy, where the threshold is crossed in that same step, and again with the buffer completely full. Each step is judged by the head message, head-valid and stall outputs one edge later. A separate directed run forces two arrivals into a full buffer. It then checks that the error flag sticks and that draining yields only the messages stored before the overflow.

// File: rtl/rx_stall_fifo.sv
module rx_stall_fifo #(
  parameter int DATA_W   = 32,
  parameter int WORK     = 4,
  parameter int HALT_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lft_vld,
  input  logic [DATA_W-1:0] lft_msg,
  input  logic              rgt_vld,
  input  logic [DATA_W-1:0] rgt_msg,
  input  logic              rd_en,
  output logic              head_vld,
  output logic [DATA_W-1:0] head_msg,
  output logic              stall_req,
  output logic              ovf_err
);
  localparam int ARR   = 2;
  localparam int SLACK = ARR * HALT_LAT;
  localparam int DEPTH = WORK + SLACK;
  localparam int TH    = WORK - ARR + 1;
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 3);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr, wr_ptr2;
  logic [CW-1:0]     cnt, base, room, cnt_nxt;
  logic              do_pop, acc_l, acc_r, drop;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign do_pop  = rd_en && (cnt != '0);
  assign base    = cnt - CW'(do_pop);
  assign room    = CW'(DEPTH) - base;
  assign acc_l   = lft_vld && (room >= CW'(1));
  assign acc_r   = rgt_vld && (room >= (acc_l ? CW'(2) : CW'(1)));
  assign drop    = (lft_vld && !acc_l) || (rgt_vld && !acc_r);
  assign wr_ptr2 = acc_l ? inc(wr_ptr) : wr_ptr;
  assign cnt_nxt = base + CW'(acc_l) + CW'(acc_r);

  assign head_vld  = (cnt != '0);
  assign head_msg  = mem[rd_ptr];
  assign stall_req = (cnt >= CW'(TH));

  always_ff @(posedge clk) begin
    if (acc_l) mem[wr_ptr] <= lft_msg;
    if (acc_r) mem[wr_ptr2] <= rgt_msg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      ovf_err <= 1'b0;
    end else begin
      if (acc_r)      wr_ptr <= inc(wr_ptr2);
      else if (acc_l) wr_ptr <= inc(wr_ptr);
      if (do_pop) rd_ptr <= inc(rd_ptr);
      cnt <= cnt_nxt;
      if (drop) ovf_err <= 1'b1;
    end
  end

  // R5: occupancy never exceeds total capacity
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R3: the stall request only rises after an arrival
  assert_stall_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_req) |-> $past(lft_vld || rgt_vld));

  // R4: the stall request only falls after a removal
  assert_stall_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_req) |-> $past(rd_en));

  // R9: the error flag is sticky
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  // R7: a removal on an empty buffer leaves it empty
  assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!head_vld && !lft_vld && !rgt_vld) |=> !head_vld);

  // R2: with no traffic the head message stays put
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (head_vld && !rd_en && !lft_vld && !rgt_vld) |=> ($stable(head_msg) && head_vld));
endmodule

// File: tb/sim_rx_stall_fifo.sv
`timescale 1ns/1ps
module sim_rx_stall_fifo;
  localparam int DW = 32;
  localparam int NV = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lft_vld = 1'b0, rgt_vld = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] lft_msg = '0, rgt_msg = '0;
  logic          head_vld, stall_req, ovf_err;
  logic [DW-1:0] head_msg;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  rx_stall_fifo #(.DATA_W(DW), .WORK(4), .HALT_LAT(1)) u0 (
    .clk(clk), .rst_n(rst_n),
    .lft_vld(lft_vld), .lft_msg(lft_msg),
    .rgt_vld(rgt_vld), .rgt_msg(rgt_msg),
    .rd_en(rd_en), .head_vld(head_vld), .head_msg(head_msg),
    .stall_req(stall_req), .ovf_err(ovf_err)
  );

  // fields: lv rv pop | ldata rdata | exp_hv exp_stall exp_head
  localparam logic [28:0] VEC [NV] = '{
    {3'b100, 8'h11, 8'h00, 2'b10, 8'h11},  // single left arrival
    {3'b110, 8'h12, 8'h13, 2'b11, 8'h11},  // R1 double arrival, R3 stall at 3
    {3'b001, 8'h00, 8'h00, 2'b10, 8'h12},  // R4 release at 2
    {3'b111, 8'h14, 8'h15, 2'b11, 8'h13},  // R6 pop + two pushes
    {3'b110, 8'h16, 8'h17, 2'b11, 8'h13},  // R5 slack absorbs arrivals during stall
    {3'b010, 8'h00, 8'h18, 2'b11, 8'h13},  // R5 exactly full
    {3'b101, 8'h19, 8'h00, 2'b11, 8'h14},  // R6 pop + push while full
    {3'b001, 8'h00, 8'h00, 2'b11, 8'h15},
    {3'b001, 8'h00, 8'h00, 2'b11, 8'h16},
    {3'b001, 8'h00, 8'h00, 2'b11, 8'h17},
    {3'b001, 8'h00, 8'h00, 2'b10, 8'h18},  // R4 drop below threshold
    {3'b011, 8'h00, 8'h1A, 2'b10, 8'h19},
    {3'b001, 8'h00, 8'h00, 2'b10, 8'h1A},
    {3'b001, 8'h00, 8'h00, 2'b00, 8'h00},  // R8 empty
    {3'b001, 8'h00, 8'h00, 2'b00, 8'h00},  // R7 pop on empty
    {3'b100, 8'h1B, 8'h00, 2'b10, 8'h1B},  // R7 arrival after empty pop
    {3'b001, 8'h00, 8'h00, 2'b00, 8'h00}
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic lv, input logic [7:0] ld, input logic rv,
                      input logic [7:0] rd, input logic pp);
    lft_vld = lv; lft_msg = {24'h0, ld};
    rgt_vld = rv; rgt_msg = {24'h0, rd};
    rd_en = pp;
    @(negedge clk);
    lft_vld = 1'b0; rgt_vld = 1'b0; rd_en = 1'b0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk("R10 head_vld", DW'(head_vld), 0);
    chk("R10 stall_req", DW'(stall_req), 0);
    chk("R10 ovf_err", DW'(ovf_err), 0);

    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      step(v[28], v[25:18], v[27], v[17:10], v[26]);
      chk($sformatf("R8 head_vld vec %0d", i), DW'(head_vld), DW'(v[9]));
      chk($sformatf("R3/R4 stall_req vec %0d", i), DW'(stall_req), DW'(v[8]));
      chk($sformatf("R5 ovf_err vec %0d", i), DW'(ovf_err), 0);
      if (v[9])
        chk($sformatf("R1/R2/R6 head_msg vec %0d", i), head_msg, {24'h0, v[7:0]});
    end

    // R9 overflow: fill, then push two into a full buffer
    step(1, 8'h21, 1, 8'h22, 0);
    step(1, 8'h23, 1, 8'h24, 0);
    step(1, 8'h25, 1, 8'h26, 0);
    chk("R5 full no error", DW'(ovf_err), 0);
    step(1, 8'h27, 1, 8'h28, 0);
    chk("R9 ovf_err set", DW'(ovf_err), 1);
    chk("R9 head kept", head_msg, 32'h21);
    for (int k = 0; k < 5; k++) step(0, 8'h00, 0, 8'h00, 1);
    chk("R9 last stored", head_msg, 32'h26);
    chk("R9 error sticky", DW'(ovf_err), 1);
    step(0, 8'h00, 0, 8'h00, 1);
    chk("R9 excess dropped", DW'(head_vld), 0);

    // R10 reset clears the error
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R10 ovf_err after reset", DW'(ovf_err), 0);
    chk("R10 empty after reset", DW'(head_vld), 0);
    summary();
  end
endmodule